// File: doc/BRIEF.md
# Victim Replica Slot Selector

This block lives in the local L2 slice of one tile in a tiled multiprocessor whose distributed L2 is shared by all tiles. When the tile's L1 evicts a line, the block always tells the line's home directory about the eviction. It also asks for a writeback to the home slice when the line is dirty. It then decides whether a replica of the victim should be kept in the local slice, and if so, which way of the target set it should overwrite.

The way is picked by a fixed ranking of line kinds. An invalid way comes first. Next is a global line, meaning one homed in this slice, that has no sharers. Last is a way that already holds a replica. A global line with remote sharers is never displaced. A victim whose home is this tile is never replicated. Within one rank the lowest-numbered way wins. The replica is written with its replica flag set and stored clean, because the home copy has already been brought up to date.

The block also serves local lookups. When a lookup's tag match lands on a replica way, the block returns that way's data and invalidates the replica in the same operation. Any other lookup result becomes a request to the home tile. Every decision is combinational from the current inputs and is registered once, so each result appears one cycle after its request.

Top module: `vr_slot_select`

## Requirements
- R1: After reset, and in any cycle that follows a cycle with no request, ins_valid, wb_req, dir_req, rep_hit and home_req are all 0.
- R2: Every accepted eviction (ev_valid=1) raises dir_req one cycle later, with dir_addr equal to the victim address and dir_home equal to the victim's home tile.
- R3: wb_req is 1 one cycle after an eviction exactly when ev_dirty was 1, and wb_addr carries the victim address.
- R4: If any way of the target set is invalid (way_valid bit 0), the insert goes to the lowest-numbered invalid way.
- R5: If every way is valid, the insert goes to the lowest-numbered way that holds a global line with no sharers (way_replica=0, way_shared=0).
- R6: If no way is invalid and no way holds an unshared global line, the insert goes to the lowest-numbered way with way_replica=1.
- R7: If every way is valid and holds a global line with sharers (way_replica=0, way_shared=1), no insert is made (ins_valid=0), while dir_req is still raised.
- R8: If ev_home equals the LOCAL_TILE parameter, no insert is made, even when invalid ways exist.
- R9: An insert appears one cycle after the eviction: ins_valid=1, ins_way is the chosen way, ins_addr is the victim address, ins_replica=1 and ins_dirty=0.
- R10: A lookup (lk_valid=1) whose one-hot tag match lk_hit selects a valid way with way_replica=1 gives rep_hit=1, rep_way set to that way, and home_req=0 one cycle later. rep_hit both returns the data and invalidates the way.
- R11: A lookup with no match, or with a match on a non-replica way, gives home_req=1 and rep_hit=0 one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | L1 eviction request |
| ev_addr | input | ADDR_W | Victim line address |
| ev_dirty | input | 1 | Victim is dirty |
| ev_home | input | TILE_W | Home tile of the victim |
| way_valid | input | WAYS | Per-way valid bits of the target set |
| way_replica | input | WAYS | Per-way replica flag |
| way_shared | input | WAYS | Per-way flag: global line has sharers |
| lk_valid | input | 1 | Local lookup request |
| lk_hit | input | WAYS | One-hot tag match of the lookup |
| ins_valid | output | 1 | Write a replica into the slice |
| ins_way | output | $clog2(WAYS) | Way to overwrite |
| ins_addr | output | ADDR_W | Address of the replica |
| ins_replica | output | 1 | Replica flag to store with the line |
| ins_dirty | output | 1 | Dirty flag to store with the line |
| wb_req | output | 1 | Writeback request to the home slice |
| wb_addr | output | ADDR_W | Writeback address |
| dir_req | output | 1 | Directory update request to the home tile |
| dir_addr | output | ADDR_W | Directory update address |
| dir_home | output | TILE_W | Home tile for the directory update |
| rep_hit | output | 1 | Lookup hit a replica: read it and invalidate it |
| rep_way | output | $clog2(WAYS) | Way of the replica hit |
| home_req | output | 1 | Lookup must go to the home tile |

## Verification
The bench sets up sets where several ways qualify at each rank, and checks that the lowest way of the highest rank wins. A design with reversed priority, or with the scan running the wrong way, would overwrite a replica while a free slot exists, or would pick a higher way. Victims homed locally are sent against a set that has invalid ways, and sets made only of shared global lines are offered as well. A design that skipped either refusal would raise ins_valid and destroy a home line or make a useless copy. In those refused cases the bench still checks that dir_req is raised. Lookups that match a global line are also run, and must go to home_req; a design that trusted the tag match alone would report a replica hit for them.

// File: rtl/vr_slot_select.sv
module vr_slot_select #(
  parameter int WAYS       = 4,
  parameter int ADDR_W     = 32,
  parameter int TILE_W     = 4,
  parameter int LOCAL_TILE = 3,
  localparam int WW        = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic              ev_dirty,
  input  logic [TILE_W-1:0] ev_home,
  input  logic [WAYS-1:0]   way_valid,
  input  logic [WAYS-1:0]   way_replica,
  input  logic [WAYS-1:0]   way_shared,
  input  logic              lk_valid,
  input  logic [WAYS-1:0]   lk_hit,
  output logic              ins_valid,
  output logic [WW-1:0]     ins_way,
  output logic [ADDR_W-1:0] ins_addr,
  output logic              ins_replica,
  output logic              ins_dirty,
  output logic              wb_req,
  output logic [ADDR_W-1:0] wb_addr,
  output logic              dir_req,
  output logic [ADDR_W-1:0] dir_addr,
  output logic [TILE_W-1:0] dir_home,
  output logic              rep_hit,
  output logic [WW-1:0]     rep_way,
  output logic              home_req
);

  logic [WAYS-1:0] free_inv, free_glb, free_rep, rep_match;
  logic [WW-1:0]   inv_way, glb_way, old_way, pick_way, hit_way;
  logic            pick_ok, is_local, hit_rep;

  assign free_inv  = ~way_valid;
  assign free_glb  = way_valid & ~way_replica & ~way_shared;
  assign free_rep  = way_valid & way_replica;
  assign rep_match = lk_hit & way_valid & way_replica;
  assign is_local  = (ev_home == TILE_W'(LOCAL_TILE));
  assign hit_rep   = |rep_match;

  always_comb begin
    inv_way = '0;
    glb_way = '0;
    old_way = '0;
    hit_way = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (free_inv[i])  inv_way = WW'(i);
      if (free_glb[i])  glb_way = WW'(i);
      if (free_rep[i])  old_way = WW'(i);
      if (rep_match[i]) hit_way = WW'(i);
    end
  end

  always_comb begin
    pick_ok  = 1'b1;
    pick_way = '0;
    if (|free_inv)      pick_way = inv_way;
    else if (|free_glb) pick_way = glb_way;
    else if (|free_rep) pick_way = old_way;
    else                pick_ok  = 1'b0;
    if (is_local)       pick_ok  = 1'b0;
  end

  assign ins_replica = 1'b1;
  assign ins_dirty   = 1'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ins_valid <= 1'b0;
      ins_way   <= '0;
      ins_addr  <= '0;
      wb_req    <= 1'b0;
      wb_addr   <= '0;
      dir_req   <= 1'b0;
      dir_addr  <= '0;
      dir_home  <= '0;
      rep_hit   <= 1'b0;
      rep_way   <= '0;
      home_req  <= 1'b0;
    end else begin
      ins_valid <= ev_valid && pick_ok;
      ins_way   <= pick_way;
      ins_addr  <= ev_addr;
      wb_req    <= ev_valid && ev_dirty;
      wb_addr   <= ev_addr;
      dir_req   <= ev_valid;
      dir_addr  <= ev_addr;
      dir_home  <= ev_home;
      rep_hit   <= lk_valid && hit_rep;
      rep_way   <= hit_way;
      home_req  <= lk_valid && !hit_rep;
    end
  end

endmodule

// File: rtl/vr_slot_select_chk.sv
module vr_slot_select_chk #(
  parameter int WAYS       = 4,
  parameter int ADDR_W     = 32,
  parameter int TILE_W     = 4,
  parameter int LOCAL_TILE = 3,
  localparam int WW        = $clog2(WAYS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_valid,
  input logic              ev_dirty,
  input logic [TILE_W-1:0] ev_home,
  input logic [WAYS-1:0]   way_valid,
  input logic              lk_valid,
  input logic              ins_valid,
  input logic [WW-1:0]     ins_way,
  input logic              wb_req,
  input logic              dir_req,
  input logic              rep_hit,
  input logic              home_req
);

  logic [WAYS-1:0] seen_valid;
  always_ff @(posedge clk) seen_valid <= way_valid;

  assert_dir_always_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |=> dir_req);

  assert_wb_dirty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_dirty |=> wb_req);

  assert_wb_only_dirty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_valid && ev_dirty) |=> !wb_req);

  assert_local_refused_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_home == TILE_W'(LOCAL_TILE) |=> !ins_valid);

  assert_invalid_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && ins_valid && seen_valid[ins_way] |-> (&seen_valid));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_valid && !lk_valid |=> !ins_valid && !dir_req && !rep_hit && !home_req);

  assert_lookup_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rep_hit != home_req);

endmodule

bind vr_slot_select vr_slot_select_chk #(
  .WAYS(WAYS), .ADDR_W(ADDR_W), .TILE_W(TILE_W), .LOCAL_TILE(LOCAL_TILE)
) u_chk (.*);

// File: tb/tb_vr_slot_select.sv
module tb_vr_slot_select;
  localparam int CLK_P  = 10;
  localparam int WAYS   = 4;
  localparam int ADDR_W = 32;
  localparam int TILE_W = 4;
  localparam int LOCAL  = 3;

  logic clk = 0, rst_n = 0;
  logic ev_valid = 0, ev_dirty = 0, lk_valid = 0;
  logic [ADDR_W-1:0] ev_addr = '0;
  logic [TILE_W-1:0] ev_home = '0;
  logic [WAYS-1:0] way_valid = '0, way_replica = '0, way_shared = '0, lk_hit = '0;
  logic ins_valid, ins_replica, ins_dirty, wb_req, dir_req, rep_hit, home_req;
  logic [1:0] ins_way, rep_way;
  logic [ADDR_W-1:0] ins_addr, wb_addr, dir_addr;
  logic [TILE_W-1:0] dir_home;

  int total = 0, bad = 0;

  vr_slot_select #(.WAYS(WAYS), .ADDR_W(ADDR_W), .TILE_W(TILE_W), .LOCAL_TILE(LOCAL)) dut (.*);

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic evict(logic [ADDR_W-1:0] a, logic d, logic [TILE_W-1:0] h,
                       logic [WAYS-1:0] v, logic [WAYS-1:0] r, logic [WAYS-1:0] s);
    @(negedge clk);
    ev_valid = 1; ev_addr = a; ev_dirty = d; ev_home = h;
    way_valid = v; way_replica = r; way_shared = s;
    @(negedge clk);
    ev_valid = 0;
  endtask

  task automatic lookup(logic [WAYS-1:0] hit, logic [WAYS-1:0] v, logic [WAYS-1:0] r);
    @(negedge clk);
    lk_valid = 1; lk_hit = hit; way_valid = v; way_replica = r;
    @(negedge clk);
    lk_valid = 0;
  endtask

  task automatic t_reset;
    chk("R1 ins", ins_valid, 0); chk("R1 wb", wb_req, 0);
    chk("R1 dir", dir_req, 0);   chk("R1 rep", rep_hit, 0);
    chk("R1 home", home_req, 0);
  endtask

  task automatic t_invalid_first;
    evict(32'h1000, 1, 5, 4'b1001, 4'b0001, 4'b0000);
    chk("R4 ins", ins_valid, 1); chk("R4 way", ins_way, 1);
    chk("R9 addr", ins_addr, 32'h1000); chk("R9 rep", ins_replica, 1);
    chk("R9 clean", ins_dirty, 0);
    chk("R2 dir", dir_req, 1); chk("R2 addr", dir_addr, 32'h1000);
    chk("R2 home", dir_home, 5);
    chk("R3 wb", wb_req, 1); chk("R3 addr", wb_addr, 32'h1000);
    @(negedge clk);
    chk("R1 idle ins", ins_valid, 0); chk("R1 idle dir", dir_req, 0);
  endtask

  task automatic t_global_next;
    evict(32'h2040, 0, 7, 4'b1111, 4'b0001, 4'b0010);
    chk("R5 ins", ins_valid, 1); chk("R5 way", ins_way, 2);
    chk("R3 clean no wb", wb_req, 0);
  endtask

  task automatic t_replica_last;
    evict(32'h3000, 0, 1, 4'b1111, 4'b1010, 4'b0101);
    chk("R6 ins", ins_valid, 1); chk("R6 way", ins_way, 1);
  endtask

  task automatic t_all_shared;
    evict(32'h4000, 1, 2, 4'b1111, 4'b0000, 4'b1111);
    chk("R7 no ins", ins_valid, 0); chk("R7 dir", dir_req, 1);
    chk("R7 wb", wb_req, 1);
  endtask

  task automatic t_local_home;
    evict(32'h5000, 0, LOCAL, 4'b0000, 4'b0000, 4'b0000);
    chk("R8 no ins", ins_valid, 0); chk("R8 dir", dir_req, 1);
    chk("R8 home", dir_home, LOCAL);
  endtask

  task automatic t_lookups;
    lookup(4'b0100, 4'b1111, 4'b0100);
    chk("R10 hit", rep_hit, 1); chk("R10 way", rep_way, 2);
    chk("R10 no home", home_req, 0);
    lookup(4'b0000, 4'b1111, 4'b0100);
    chk("R11 miss home", home_req, 1); chk("R11 miss rep", rep_hit, 0);
    lookup(4'b0010, 4'b1111, 4'b0100);
    chk("R11 global home", home_req, 1); chk("R11 global rep", rep_hit, 0);
  endtask

  initial begin
    #(CLK_P * 20000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_invalid_first;
    t_global_next;
    t_replica_last;
    t_all_shared;
    t_local_home;
    t_lookups;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule